// File: doc/BRIEF.md
# Timestamp-Ordered Strict Cell Resequencer

This block restores timestamp order for one output of a dynamically routed, buffered switch fabric. Cells reach the output out of order because they take different paths through the fabric. Each cell carries the value that a free-running time counter held when the cell entered the fabric. The block keeps every cell until its age is exactly `T` cycles, then hands it on. Cells therefore leave in timestamp order, and cells with the same timestamp leave in the order they arrived. The block is strict: a cell that is already `T` cycles old when it arrives has missed its turn, so it is discarded and reported on a drop strobe.

The held cells are sorted by a timing wheel with `T = 2**SLOT_W` slots. Each slot is the head of a linked list kept in one shared cell memory, and a stack of unused entry indices hands out and takes back memory entries. One cycle before a slot's cells reach age `T`, the whole list of that slot is spliced onto the tail of a ready list in a single step. The output side then pops the ready list one cell per handshake. Every cell costs a fixed amount of work, whatever the occupancy.

The block owns the time counter and drives its value on `time_o`, so that upstream logic can stamp cells with it. The age of a cell is `time_o - ts`, taken modulo `2**TS_W`.

Top module: `cell_reseq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is 0, `in_ready` is 1, `drop_o` is 0 and `time_o` is 0. After that, `time_o` rises by one on every clock edge and wraps modulo `2**TS_W`.
- R2: A cell accepted with age `time_o - in_ts` (modulo `2**TS_W`) below `T` never appears on the output while its age is below `T`. If the ready list is empty and `out_ready` is high, the cell first appears in the cycle its age equals `T`.
- R3: Output timestamps never decrease. Cells with equal timestamps leave in the order they were accepted.
- R4: A cell accepted with an age of `T` or more is discarded and never appears on the output. `drop_o` is high in exactly the cycle of that cell's input handshake.
- R5: `in_ready` is low exactly when all `DEPTH` memory entries hold cells that have been accepted, were not dropped, and have not yet been output.
- R6: An entry is freed on the clock edge of its cell's output handshake. When the memory was full, `in_ready` is high in the next cycle.
- R7: A cell that arrives with age `T-1` joins the slot that is draining in that same cycle. It appears one cycle later, behind any cells already in that slot.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_ts` and `out_data` hold their values into the next cycle.
- R9: Each output carries the timestamp and payload of the accepted cell it stands for, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input cell present |
| in_ready | output | 1 | Input can take a cell (a memory entry is free) |
| in_ts | input | TS_W | Timestamp of the input cell |
| in_data | input | PAY_W | Payload of the input cell |
| out_valid | output | 1 | Output cell present |
| out_ready | input | 1 | Downstream takes the output cell |
| out_ts | output | TS_W | Timestamp of the output cell |
| out_data | output | PAY_W | Payload of the output cell |
| drop_o | output | 1 | The current input handshake carries a late cell, which is discarded |
| time_o | output | TS_W | Current value of the time counter |

## Verification
Two things can land on the same slot in the same cycle: the slot is drained, and a new cell is inserted into it. This happens when a cell arrives with age `T-1` at the moment its slot is spliced onto the ready list. The bench provokes this case by placing an age-0 cell into a slot and then sending an age-`T-1` cell with the same timestamp exactly `T-1` cycles later. The first cell must appear on the output exactly at age `T` and the second in the cycle after it. The same case is also tested with an empty slot, where the single cell must appear exactly at age `T`. A separate run fills the memory while the output is stalled. It checks that the output holds steady, that `in_ready` falls, and that freeing one entry raises `in_ready` in the next cycle.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    localparam int RSQ_TS_W   = 10;
    localparam int RSQ_SLOT_W = 3;
    localparam int RSQ_DEPTH  = 16;
    localparam int RSQ_PAY_W  = 16;

    // what an accepted cell does to its wheel slot
    typedef enum logic [1:0] {
        INS_NONE   = 2'd0,
        INS_OPEN   = 2'd1,
        INS_APPEND = 2'd2
    } ins_kind_e;
endpackage

// File: rtl/rsq_freelist.sv
module rsq_freelist #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_i,
    input  logic             push_i,
    input  logic [IDX_W-1:0] push_idx_i,
    output logic             avail_o,
    output logic [IDX_W-1:0] top_idx_o
);
    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] stk;
        logic [CNT_W-1:0]            cnt;
    } fl_t;

    fl_t q, d;
    logic [IDX_W-1:0] sel_top;
    logic [IDX_W-1:0] sel_new;

    assign sel_top   = IDX_W'(q.cnt - 1'b1);
    assign sel_new   = IDX_W'(q.cnt);
    assign avail_o   = (q.cnt != '0);
    assign top_idx_o = q.stk[sel_top];

    always_comb begin
        d = q;
        case ({pop_i, push_i})
            2'b11: d.stk[sel_top] = push_idx_i;
            2'b10: d.cnt = q.cnt - 1'b1;
            2'b01: begin
                d.stk[sel_new] = push_idx_i;
                d.cnt          = q.cnt + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) q.stk[i] <= IDX_W'(i);
            q.cnt <= CNT_W'(DEPTH);
        end else begin
            q <= d;
        end
    end

    AST_FREE_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> q.cnt != '0); // R5
    AST_FREE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |-> q.cnt < CNT_W'(DEPTH)); // R6
endmodule

// File: rtl/rsq_wheel.sv
module rsq_wheel #(
    parameter int TS_W   = 10,
    parameter int SLOT_W = 3,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  now_i,
    input  logic             ins_i,
    input  logic [TS_W-1:0]  ins_ts_i,
    input  logic [IDX_W-1:0] ins_idx_i,
    output logic             spl_vld_o,
    output logic [IDX_W-1:0] spl_head_o,
    output logic [IDX_W-1:0] spl_tail_o,
    output logic             lnk_we_o,
    output logic [IDX_W-1:0] lnk_addr_o
);
    import rsq_pkg::*;

    localparam int T = 1 << SLOT_W;
    localparam logic [TS_W-1:0] T_TS = TS_W'(T);

    typedef struct packed {
        logic [T-1:0]            vld;
        logic [T-1:0][IDX_W-1:0] head;
        logic [T-1:0][IDX_W-1:0] tail;
    } wh_t;

    wh_t q, d;
    logic [SLOT_W-1:0] dsl;
    logic [SLOT_W-1:0] isl;
    logic              hit;
    ins_kind_e         kind;
    logic [TS_W-1:0]   ins_age;

    // the slot whose cells reach age T on the next edge
    assign dsl     = now_i[SLOT_W-1:0] + 1'b1;
    assign isl     = ins_ts_i[SLOT_W-1:0];
    assign hit     = ins_i && (isl == dsl);
    assign ins_age = now_i - ins_ts_i;

    always_comb begin
        if (!ins_i)          kind = INS_NONE;
        else if (q.vld[isl]) kind = INS_APPEND;
        else                 kind = INS_OPEN;
    end

    assign lnk_we_o   = (kind == INS_APPEND);
    assign lnk_addr_o = q.tail[isl];
    assign spl_vld_o  = q.vld[dsl] || hit;
    assign spl_head_o = q.vld[dsl] ? q.head[dsl] : ins_idx_i;
    assign spl_tail_o = hit ? ins_idx_i : q.tail[dsl];

    always_comb begin
        d = q;
        if (ins_i && !hit) begin
            if (kind == INS_APPEND) begin
                d.tail[isl] = ins_idx_i;
            end else begin
                d.vld[isl]  = 1'b1;
                d.head[isl] = ins_idx_i;
                d.tail[isl] = ins_idx_i;
            end
        end
        d.vld[dsl] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_WHEEL_INS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ins_i |-> ins_age < T_TS); // R4
    AST_WHEEL_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        spl_vld_o |=> !q.vld[$past(dsl)]); // R7
endmodule

// File: rtl/cell_reseq.sv
module cell_reseq #(
    parameter int TS_W   = rsq_pkg::RSQ_TS_W,
    parameter int SLOT_W = rsq_pkg::RSQ_SLOT_W,
    parameter int DEPTH  = rsq_pkg::RSQ_DEPTH,
    parameter int PAY_W  = rsq_pkg::RSQ_PAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TS_W-1:0]  in_ts,
    input  logic [PAY_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [TS_W-1:0]  out_ts,
    output logic [PAY_W-1:0] out_data,
    output logic             drop_o,
    output logic [TS_W-1:0]  time_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int T     = 1 << SLOT_W;
    localparam logic [TS_W-1:0] T_TS = TS_W'(T);
    localparam logic [TS_W-1:0] HALF = TS_W'(1) << (TS_W - 1);

    typedef struct packed {
        logic [TS_W-1:0]              now;
        logic [DEPTH-1:0][IDX_W-1:0]  nxt;
        logic [DEPTH-1:0][TS_W-1:0]   cts;
        logic [DEPTH-1:0][PAY_W-1:0]  pay;
        logic                         rvld;
        logic [IDX_W-1:0]             rhead;
        logic [IDX_W-1:0]             rtail;
    } top_t;

    top_t q, d;

    logic [TS_W-1:0]  age;
    logic             late;
    logic             fire_in;
    logic             keep;
    logic             pop;
    logic             last;
    logic             fl_avail;
    logic [IDX_W-1:0] fl_idx;
    logic             spl_vld;
    logic [IDX_W-1:0] spl_head;
    logic [IDX_W-1:0] spl_tail;
    logic             lnk_we;
    logic [IDX_W-1:0] lnk_addr;
    logic [TS_W-1:0]  out_age;

    assign age     = q.now - in_ts;
    assign late    = (age >= T_TS);
    assign fire_in = in_valid && fl_avail;
    assign keep    = fire_in && !late;
    assign pop     = q.rvld && out_ready;
    assign last    = pop && (q.rhead == q.rtail);

    assign in_ready  = fl_avail;
    assign drop_o    = fire_in && late;
    assign time_o    = q.now;
    assign out_valid = q.rvld;
    assign out_ts    = q.cts[q.rhead];
    assign out_data  = q.pay[q.rhead];
    assign out_age   = q.now - out_ts;

    rsq_freelist #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_i      (keep),
        .push_i     (pop),
        .push_idx_i (q.rhead),
        .avail_o    (fl_avail),
        .top_idx_o  (fl_idx)
    );

    rsq_wheel #(.TS_W(TS_W), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_wheel (
        .clk        (clk),
        .rst_n      (rst_n),
        .now_i      (q.now),
        .ins_i      (keep),
        .ins_ts_i   (in_ts),
        .ins_idx_i  (fl_idx),
        .spl_vld_o  (spl_vld),
        .spl_head_o (spl_head),
        .spl_tail_o (spl_tail),
        .lnk_we_o   (lnk_we),
        .lnk_addr_o (lnk_addr)
    );

    always_comb begin
        d     = q;
        d.now = q.now + 1'b1;
        if (keep) begin
            d.cts[fl_idx] = in_ts;
            d.pay[fl_idx] = in_data;
        end
        if (lnk_we) d.nxt[lnk_addr] = fl_idx;
        if (spl_vld) begin
            if (q.rvld && !last) begin
                d.nxt[q.rtail] = spl_head;
                d.rtail        = spl_tail;
                if (pop) d.rhead = q.nxt[q.rhead];
            end else begin
                d.rvld  = 1'b1;
                d.rhead = spl_head;
                d.rtail = spl_tail;
            end
        end else if (pop) begin
            if (last) d.rvld  = 1'b0;
            else      d.rhead = q.nxt[q.rhead];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_ts) && $stable(out_data)); // R8
    AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_age >= T_TS); // R2
    AST_TS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid || ((out_ts - $past(out_ts)) < HALF)); // R3
    AST_DROP_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> $stable(in_ready) || $past(pop)); // R4
endmodule

// File: tb/sim_cell_reseq.sv
`timescale 1ns/1ps
module sim_cell_reseq;
    localparam int TS_W = 10;
    localparam int T    = 8;
    localparam int DEPTH = 16;
    localparam int NV   = 24;
    localparam int MAXC = 256;

    // [28]=out_ready, [24]=in_valid, [23:16]=age at injection, [15:0]=payload
    localparam logic [31:0] VEC [NV] = '{
        32'h11031001, 32'h11001002, 32'h11071003, 32'h11051004,
        32'h11081005, 32'h11021006, 32'h01011007, 32'h01061008,
        32'h110A1009, 32'h1104100A, 32'h10000000, 32'h1107100B,
        32'h1107100C, 32'h0100100D, 32'h1103100E, 32'h1109100F,
        32'h11011010, 32'h10000000, 32'h11061011, 32'h01021012,
        32'h11051013, 32'h11001014, 32'h11081015, 32'h11031016
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [TS_W-1:0] in_ts = '0;
    logic [15:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [TS_W-1:0] out_ts;
    logic [15:0] out_data;
    logic drop_o;
    logic [TS_W-1:0] time_o;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int n_cells = 0;
    int exp_drop = 0;
    int obs_drop = 0;
    int last_id = -1;
    bit finished = 1'b0;
    int m_uts [MAXC];
    int m_pay [MAXC];
    int m_out [MAXC];
    bit m_done [MAXC];

    always #10 clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    cell_reseq u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ts(in_ts), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_ts(out_ts), .out_data(out_data), .drop_o(drop_o), .time_o(time_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic take_output();
        int best;
        best = -1;
        for (int i = 0; i < n_cells; i++)
            if (!m_done[i] && (best < 0 || m_uts[i] < m_uts[best])) best = i;
        chk(best >= 0, "R4 output with no pending cell", int'(out_data), -1);
        if (best >= 0) begin
            chk(int'(out_data) == m_pay[best], "R3 order and R9 payload", int'(out_data), m_pay[best]);
            chk(int'(out_ts) == (m_uts[best] & 1023), "R9 timestamp", int'(out_ts), m_uts[best] & 1023);
            chk(cyc - m_uts[best] >= T, "R2 age at output", cyc - m_uts[best], T);
            m_done[best] = 1'b1;
            m_out[best]  = cyc;
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit iv, input int dly, input int pay, input bit ordy);
        last_id   = -1;
        in_valid  = iv;
        in_ts     = time_o - TS_W'(dly);
        in_data   = pay[15:0];
        out_ready = ordy;
        #1;
        if (drop_o) obs_drop++;
        if (out_valid && out_ready) take_output();
        if (in_valid && in_ready) begin
            if (dly >= T) begin
                exp_drop++;
                chk(drop_o == 1'b1, "R4 drop strobe on late cell", int'(drop_o), 1);
            end else begin
                chk(drop_o == 1'b0, "R4 no drop on timely cell", int'(drop_o), 0);
                m_uts[n_cells]  = cyc - dly;
                m_pay[n_cells]  = pay;
                m_done[n_cells] = 1'b0;
                last_id = n_cells;
                n_cells++;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b1);
    endtask

    function automatic int pending();
        int c;
        c = 0;
        for (int i = 0; i < n_cells; i++) if (!m_done[i]) c++;
        return c;
    endfunction

    initial begin
        int a;
        int b;
        int t0;
        int hold_d;
        int hold_t;
        bit have_hold;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        chk(time_o == '0, "R1 time in reset", int'(time_o), 0);
        rst_n = 1'b1;
        #1;
        chk(drop_o == 1'b0, "R1 drop after reset", int'(drop_o), 0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(int'(time_o) == 3, "R1 time counts", int'(time_o), 3);
        chk(int'(time_o) == (cyc & 1023), "R1 time tracks cycles", int'(time_o), cyc & 1023);

        // table walk
        for (int v = 0; v < NV; v++)
            step(VEC[v][24], int'(VEC[v][23:16]), int'(VEC[v][15:0]), VEC[v][28]);
        idle(20);
        chk(pending() == 0, "R2 all timely cells released", pending(), 0);
        chk(obs_drop == exp_drop, "R4 drop count", obs_drop, exp_drop);
        chk(exp_drop == 4, "R4 table late cells", exp_drop, 4);

        // exact latency, age 0
        step(1'b1, 0, 16'h3001, 1'b1);
        a = last_id;
        idle(T + 4);
        chk(a >= 0 && m_done[a], "R2 single cell released", 0, 1);
        if (a >= 0) chk(m_out[a] - m_uts[a] == T, "R2 exact release age", m_out[a] - m_uts[a], T);

        // age T-1 alone: joins the draining slot
        step(1'b1, T - 1, 16'h3002, 1'b1);
        a = last_id;
        idle(4);
        if (a >= 0) chk(m_out[a] - m_uts[a] == T, "R7 age T-1 single", m_out[a] - m_uts[a], T);
        else chk(1'b0, "R7 age T-1 accepted", 0, 1);

        // same slot drain and insert in one cycle
        t0 = cyc;
        step(1'b1, 0, 16'h3003, 1'b1);
        a = last_id;
        idle(T - 2);
        step(1'b1, T - 1, 16'h3004, 1'b1);
        b = last_id;
        idle(5);
        if (a >= 0 && b >= 0) begin
            chk(m_uts[b] == t0, "R7 shared timestamp", m_uts[b], t0);
            chk(m_out[a] == t0 + T, "R7 earlier cell first", m_out[a], t0 + T);
            chk(m_out[b] == t0 + T + 1, "R7 joining cell behind", m_out[b], t0 + T + 1);
        end else chk(1'b0, "R7 both accepted", a, b);

        // exact late boundary
        exp_drop = 0;
        obs_drop = 0;
        step(1'b1, T, 16'h3005, 1'b1);
        idle(T + 3);
        chk(obs_drop == 1, "R4 age T dropped", obs_drop, 1);
        chk(pending() == 0, "R4 nothing left after drop", pending(), 0);

        // fill memory with output stalled
        have_hold = 1'b0;
        hold_d = 0;
        hold_t = 0;
        for (int i = 0; i < DEPTH + T + 4; i++) begin
            step(1'b1, 0, 16'h4000 + i, 1'b0);
            if (out_valid) begin
                if (have_hold) begin
                    chk(int'(out_data) == hold_d, "R8 data held", int'(out_data), hold_d);
                    chk(int'(out_ts) == hold_t, "R8 ts held", int'(out_ts), hold_t);
                end
                have_hold = 1'b1;
                hold_d = int'(out_data);
                hold_t = int'(out_ts);
            end
        end
        chk(have_hold, "R8 output presented while stalled", int'(have_hold), 1);
        chk(in_ready == 1'b0, "R5 full memory blocks input", int'(in_ready), 0);
        chk(pending() == DEPTH, "R5 accepted exactly DEPTH", pending(), DEPTH);
        step(1'b0, 0, 0, 1'b1);
        chk(in_ready == 1'b1, "R6 freed entry reopens input", int'(in_ready), 1);
        idle(DEPTH + 10);
        chk(pending() == 0, "R6 drain after full", pending(), 0);
        chk(in_ready == 1'b1, "R5 empty memory accepts", int'(in_ready), 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule